// File: doc/BRIEF.md
# Clause-22 Window onto Extended Device Registers

This block sits on the PHY side of a management link. A station that can only issue
Clause-22 style register accesses (5-bit register number, 16-bit data) uses it to reach
the much larger extended register space of the manageable devices inside the PHY. Two of
the 32 basic register numbers are claimed as a window. Register 13 is a control word: its
low five bits pick a device number and its top two bits pick a function. Register 14 is
the data word. What register 14 carries depends on the function field. It carries either
an extended register address or the contents of the register that address points at.

One 16-bit address latch exists for each of the 32 device numbers, so switching devices
does not lose the pointer of another device. Data accesses through register 14 become
single-cycle strobes on an internal extended-register port. After such a strobe, the
latched address of the selected device may step by one, as the function field selects.
Every other basic register number passes straight through to a separate basic register port.

A typical sequence has four steps. Write the device number to register 13. Write the
target address to register 14. Write register 13 again with the device number and a data
function. Then read or write register 14, repeating the access to stream through
consecutive registers.

Top module: `c22_ext_window`

## Requirements
- R1: After reset the control word reads 0x0000 and the address latches of all 32 devices hold 0.
- R2: A write to register 13 stores all 16 bits; a later read of register 13 returns them. Bits [4:0] are the device number and bits [15:14] are the function.
- R3: With function 00, a write to register 14 loads the written value into the address latch of the selected device, and a read of register 14 returns that latch.
- R4: Each device number has its own latch; loading or stepping the latch of one device leaves the latches of all other devices unchanged.
- R5: With a non-zero function, a read of register 14 raises one extended-port strobe with write enable low, carrying the selected device and its latched address. The read returns the extended port's read data.
- R6: With a non-zero function, a write of register 14 raises one extended-port strobe with write enable high, carrying the device, the latched address and the written data.
- R7: Function 01 never changes the latched address.
- R8: Function 10 adds one to the latched address after every data read and every data write.
- R9: Function 11 adds one to the latched address after data writes only; data reads leave it unchanged.
- R10: Address stepping wraps from 0xFFFF to 0x0000, and the stepped value is in effect for the very next access.
- R11: Accesses to register numbers other than 13 and 14 go to the basic register port unchanged. Read data comes back from that port. The control word and the latches are not affected, and no extended-port strobe occurs.
- R12: Each read request is answered on the management read port one clock cycle later, marked by a one-cycle valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mg_req | input | 1 | Management access strobe, one cycle per access |
| mg_we | input | 1 | 1 = write, 0 = read |
| mg_addr | input | 5 | Basic register number |
| mg_wdata | input | 16 | Management write data |
| mg_rdata | output | 16 | Management read data, registered |
| mg_rvalid | output | 1 | Read data valid pulse |
| base_req | output | 1 | Basic register port strobe |
| base_we | output | 1 | Basic register port write enable |
| base_addr | output | 5 | Basic register port register number |
| base_wdata | output | 16 | Basic register port write data |
| base_rdata | input | 16 | Basic register port read data, same cycle |
| ext_req | output | 1 | Extended register port strobe |
| ext_we | output | 1 | Extended register port write enable |
| ext_dev | output | 5 | Extended register port device number |
| ext_addr | output | 16 | Extended register port register address |
| ext_wdata | output | 16 | Extended register port write data |
| ext_rdata | input | 16 | Extended register port read data, same cycle |

## Verification
The strobes on both downstream ports are combinational from the management request, so the bench records them at the rising edge that closes the request. Read data and its valid pulse are registered and are due one cycle after the request, and the bench samples them at the falling edge that follows. A latch change from a load or a step is due at that same edge and takes effect for the next request. The bench therefore checks each stepping rule by observing the address the following access carries, or by switching to function 00 and reading the latch back. Sweeps cover every device number, all four functions with both directions, the wrap point and every passthrough register number.

// File: rtl/c22_ext_window_pkg.sv
package c22_ext_window_pkg;

   typedef enum logic [1:0] {
      FN_ADDR    = 2'b00,
      FN_HOLD    = 2'b01,
      FN_STEP_RW = 2'b10,
      FN_STEP_WR = 2'b11
   } win_fn_e;

   // Decide whether a completed data access steps the latched address.
   function automatic logic fn_steps(input win_fn_e fn, input logic is_write);
      case (fn)
         FN_STEP_RW: fn_steps = 1'b1;
         FN_STEP_WR: fn_steps = is_write;
         default:    fn_steps = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/c22_win_ctrl.sv
module c22_win_ctrl
   import c22_ext_window_pkg::*;
#(
   parameter int unsigned DW    = 16,
   parameter int unsigned DEV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [DW-1:0]    wr_data,
   output logic [DW-1:0]    ctrl_q,
   output logic [DEV_W-1:0] dev_sel,
   output win_fn_e          fn_sel
);

   initial begin
      if (DEV_W > DW - 2)
         $error("device field overlaps function field");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (wr_en)
         ctrl_q <= wr_data;
   end

   assign dev_sel = ctrl_q[DEV_W-1:0];
   assign fn_sel  = win_fn_e'(ctrl_q[DW-1 -: 2]);

   // R2: a control write is held exactly as written
   a_r2_ctrl_store: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ctrl_q == $past(wr_data));

   a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ctrl_q));

endmodule

// File: rtl/c22_win_addr_bank.sv
module c22_win_addr_bank #(
   parameter int unsigned AW    = 16,
   parameter int unsigned DEV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEV_W-1:0] sel,
   input  logic             load_en,
   input  logic [AW-1:0]    load_val,
   input  logic             step_en,
   output logic [AW-1:0]    cur
);

   localparam int unsigned NDEV = 1 << DEV_W;

   initial begin
      if (NDEV > 256)
         $error("device count too large for an address bank");
   end

   logic [AW-1:0] lat [NDEV];

   generate
      for (genvar g = 0; g < NDEV; g++) begin : g_lat
         logic hit;
         assign hit = (sel == DEV_W'(g));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lat[g] <= '0;
            else if (hit && load_en)
               lat[g] <= load_val;
            else if (hit && step_en)
               lat[g] <= lat[g] + 1'b1;
         end
      end
   endgenerate

   assign cur = lat[sel];

   // R8 / R10: step adds one modulo 2^AW to the selected entry
   a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !load_en) |=> lat[$past(sel)] == AW'($past(cur) + 1'b1));

   // R10: the all-ones address wraps to zero
   a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !load_en && (&cur)) |=> lat[$past(sel)] == '0);

   // R3: load writes the selected entry
   a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> lat[$past(sel)] == $past(load_val));

endmodule

// File: rtl/c22_win_rd_ret.sv
module c22_win_rd_ret
   import c22_ext_window_pkg::*;
#(
   parameter int unsigned DW = 16,
   parameter int unsigned AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_req,
   input  logic          hit_ctrl,
   input  logic          hit_data,
   input  win_fn_e       fn_sel,
   input  logic [DW-1:0] ctrl_q,
   input  logic [AW-1:0] cur_addr,
   input  logic [DW-1:0] ext_rdata,
   input  logic [DW-1:0] base_rdata,
   output logic [DW-1:0] rdata,
   output logic          rvalid
);

   logic [DW-1:0] rd_sel;

   always_comb begin
      if (hit_ctrl)
         rd_sel = ctrl_q;
      else if (hit_data && fn_sel == FN_ADDR)
         rd_sel = DW'(cur_addr);
      else if (hit_data)
         rd_sel = ext_rdata;
      else
         rd_sel = base_rdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= rd_req;
         if (rd_req)
            rdata <= rd_sel;
      end
   end

   // R12: one valid pulse per read, one cycle later
   a_r12_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rvalid);

   a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rvalid);

endmodule

// File: rtl/c22_ext_window.sv
module c22_ext_window
   import c22_ext_window_pkg::*;
#(
   parameter int unsigned REG_AW   = 5,
   parameter int unsigned DW       = 16,
   parameter int unsigned AW       = 16,
   parameter int unsigned DEV_W    = 5,
   parameter int unsigned CTRL_IDX = 13,
   parameter int unsigned DATA_IDX = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mg_req,
   input  logic              mg_we,
   input  logic [REG_AW-1:0] mg_addr,
   input  logic [DW-1:0]     mg_wdata,
   output logic [DW-1:0]     mg_rdata,
   output logic              mg_rvalid,
   output logic              base_req,
   output logic              base_we,
   output logic [REG_AW-1:0] base_addr,
   output logic [DW-1:0]     base_wdata,
   input  logic [DW-1:0]     base_rdata,
   output logic              ext_req,
   output logic              ext_we,
   output logic [DEV_W-1:0]  ext_dev,
   output logic [AW-1:0]     ext_addr,
   output logic [DW-1:0]     ext_wdata,
   input  logic [DW-1:0]     ext_rdata
);

   localparam int unsigned NREG = 1 << REG_AW;

   initial begin
      if (CTRL_IDX >= NREG || DATA_IDX >= NREG || CTRL_IDX == DATA_IDX)
         $error("window register numbers invalid");
      if (AW > DW)
         $error("extended address wider than data word");
   end

   logic             hit_ctrl, hit_data, hit_other;
   logic [DW-1:0]    ctrl_q;
   logic [DEV_W-1:0] dev_sel;
   win_fn_e          fn_sel;
   logic [AW-1:0]    cur_addr;
   logic             data_acc, load_en, step_en;

   assign hit_ctrl  = mg_req && (mg_addr == REG_AW'(CTRL_IDX));
   assign hit_data  = mg_req && (mg_addr == REG_AW'(DATA_IDX));
   assign hit_other = mg_req && !hit_ctrl && !hit_data;

   assign data_acc = hit_data && (fn_sel != FN_ADDR);
   assign load_en  = hit_data && (fn_sel == FN_ADDR) && mg_we;
   assign step_en  = data_acc && fn_steps(fn_sel, mg_we);

   c22_win_ctrl #(.DW(DW), .DEV_W(DEV_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (hit_ctrl && mg_we),
      .wr_data (mg_wdata),
      .ctrl_q  (ctrl_q),
      .dev_sel (dev_sel),
      .fn_sel  (fn_sel)
   );

   c22_win_addr_bank #(.AW(AW), .DEV_W(DEV_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (dev_sel),
      .load_en  (load_en),
      .load_val (mg_wdata[AW-1:0]),
      .step_en  (step_en),
      .cur      (cur_addr)
   );

   c22_win_rd_ret #(.DW(DW), .AW(AW)) u_ret (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_req     (mg_req && !mg_we),
      .hit_ctrl   (hit_ctrl),
      .hit_data   (hit_data),
      .fn_sel     (fn_sel),
      .ctrl_q     (ctrl_q),
      .cur_addr   (cur_addr),
      .ext_rdata  (ext_rdata),
      .base_rdata (base_rdata),
      .rdata      (mg_rdata),
      .rvalid     (mg_rvalid)
   );

   assign base_req   = hit_other;
   assign base_we    = mg_we;
   assign base_addr  = mg_addr;
   assign base_wdata = mg_wdata;

   assign ext_req   = data_acc;
   assign ext_we    = mg_we;
   assign ext_dev   = dev_sel;
   assign ext_addr  = cur_addr;
   assign ext_wdata = mg_wdata;

   // R5 / R6: extended strobe only for register 14 under a data function
   a_r5_ext_gate: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req |-> (mg_req && mg_addr == REG_AW'(DATA_IDX) && ctrl_q[DW-1 -: 2] != 2'b00));

   // R11: the two downstream ports are never strobed together
   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(ext_req && base_req));

   // R11: passthrough access leaves the control word alone
   a_r11_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
      base_req |=> $stable(ctrl_q));

   // R7: hold function keeps the pointer
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_req && ctrl_q[DW-1 -: 2] == 2'b01) |=> $stable(ext_addr));

   // R9: reads under write-only stepping keep the pointer
   a_r9_read_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_req && !mg_we && ctrl_q[DW-1 -: 2] == 2'b11) |=> $stable(ext_addr));

endmodule

// File: tb/test_c22_ext_window.sv
module test_c22_ext_window;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mg_req = 1'b0, mg_we = 1'b0;
   logic [4:0]  mg_addr = '0;
   logic [15:0] mg_wdata = '0;
   logic [15:0] mg_rdata;
   logic        mg_rvalid;
   logic        base_req, base_we;
   logic [4:0]  base_addr;
   logic [15:0] base_wdata, base_rdata;
   logic        ext_req, ext_we;
   logic [4:0]  ext_dev;
   logic [15:0] ext_addr, ext_wdata, ext_rdata;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   c22_ext_window i_c22_ext_window (
      .clk(clk), .rst_n(rst_n),
      .mg_req(mg_req), .mg_we(mg_we), .mg_addr(mg_addr), .mg_wdata(mg_wdata),
      .mg_rdata(mg_rdata), .mg_rvalid(mg_rvalid),
      .base_req(base_req), .base_we(base_we), .base_addr(base_addr),
      .base_wdata(base_wdata), .base_rdata(base_rdata),
      .ext_req(ext_req), .ext_we(ext_we), .ext_dev(ext_dev), .ext_addr(ext_addr),
      .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
   );

   // Stand-in extended register array: 4 devices x 16 registers
   logic [15:0] tgt [64];
   function automatic logic [15:0] tgt_init(input int i);
      return 16'hC000 + 16'(i * 37);
   endfunction
   assign ext_rdata  = tgt[{ext_dev[1:0], ext_addr[3:0]}];
   assign base_rdata = {8'hB0, 3'b000, base_addr};

   int          ext_cnt = 0, base_cnt = 0;
   logic        l_we;
   logic [4:0]  l_dev;
   logic [15:0] l_addr, l_wdata;
   logic [4:0]  lb_addr;
   logic [15:0] lb_wdata;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) tgt[i] <= tgt_init(i);
      end else begin
         if (ext_req) begin
            ext_cnt <= ext_cnt + 1;
            l_we <= ext_we; l_dev <= ext_dev; l_addr <= ext_addr; l_wdata <= ext_wdata;
            if (ext_we) tgt[{ext_dev[1:0], ext_addr[3:0]}] <= ext_wdata;
         end
         if (base_req) begin
            base_cnt <= base_cnt + 1;
            lb_addr <= base_addr; lb_wdata <= base_wdata;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      mg_req = 1'b1; mg_we = 1'b1; mg_addr = a; mg_wdata = d;
      @(negedge clk);
      mg_req = 1'b0; mg_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] d);
      @(negedge clk);
      mg_req = 1'b1; mg_we = 1'b0; mg_addr = a;
      @(negedge clk);
      mg_req = 1'b0;
      d = mg_rdata;
      chk("R12 rvalid", 32'(mg_rvalid), 32'd1);
   endtask

   logic [15:0] exp_lat [32];
   logic [15:0] v;
   int          n0;

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 idle rvalid", 32'(mg_rvalid), 32'd0);
      // R1: reset state
      rd(5'd13, v); chk("R1 ctrl reset", 32'(v), 32'h0);
      for (int d = 0; d < 32; d++) begin
         wr(5'd13, 16'(d));
         rd(5'd14, v); chk("R1 latch reset", 32'(v), 32'h0);
         exp_lat[d] = 16'(d * 16'h0111) ^ 16'h5A5A;
      end
      // R2: control store / readback
      wr(5'd13, 16'hC01F); rd(5'd13, v); chk("R2 ctrl readback", 32'(v), 32'hC01F);
      // R3/R4: load every device, then read all back
      for (int d = 0; d < 32; d++) begin
         wr(5'd13, 16'(d)); wr(5'd14, exp_lat[d]);
      end
      for (int d = 31; d >= 0; d--) begin
         wr(5'd13, 16'(d)); rd(5'd14, v); chk("R3 R4 latch per device", 32'(v), 32'(exp_lat[d]));
      end
      // R5/R6/R7: hold function, device 2, address 5
      wr(5'd13, 16'h0002); wr(5'd14, 16'h0005); exp_lat[2] = 16'h0005;
      wr(5'd13, 16'h4002);
      n0 = ext_cnt;
      rd(5'd14, v);
      chk("R5 read data", 32'(v), 32'(tgt_init(2*16+5)));
      chk("R5 strobe", {l_we, 3'b0, l_dev, l_addr}, {1'b0, 3'b0, 5'd2, 16'h0005});
      chk("R5 single strobe", 32'(ext_cnt - n0), 32'd1);
      wr(5'd14, 16'hBEEF);
      chk("R6 strobe", {l_we, 3'b0, l_dev, l_addr}, {1'b1, 3'b0, 5'd2, 16'h0005});
      chk("R6 wdata", 32'(l_wdata), 32'hBEEF);
      rd(5'd14, v); chk("R7 hold after write", 32'(v), 32'hBEEF);
      chk("R7 same address", 32'(l_addr), 32'h0005);
      // R8: step after reads and writes, device 1 from 0
      wr(5'd13, 16'h0001); wr(5'd14, 16'h0000);
      wr(5'd13, 16'h8001);
      for (int k = 0; k < 4; k++) begin
         rd(5'd14, v);
         chk("R8 read addr", 32'(l_addr), 32'(k));
         chk("R8 read data", 32'(v), 32'(tgt_init(16 + k)));
      end
      for (int k = 4; k < 8; k++) begin
         wr(5'd14, 16'(16'h1000 + k));
         chk("R8 write addr", 32'(l_addr), 32'(k));
      end
      wr(5'd13, 16'h0001); rd(5'd14, v); chk("R8 final pointer", 32'(v), 32'd8);
      exp_lat[1] = 16'd8;
      // R9: write-only stepping, device 3 from 2
      wr(5'd13, 16'h0003); wr(5'd14, 16'h0002);
      wr(5'd13, 16'hC003);
      rd(5'd14, v); chk("R9 read no step", 32'(l_addr), 32'd2);
      rd(5'd14, v); chk("R9 read no step again", 32'(l_addr), 32'd2);
      wr(5'd14, 16'h7777); chk("R9 write addr", 32'(l_addr), 32'd2);
      wr(5'd14, 16'h8888); chk("R9 stepped addr", 32'(l_addr), 32'd3);
      rd(5'd14, v); chk("R9 read stepped", 32'(v), 32'(tgt_init(3*16+4)));
      wr(5'd13, 16'h0003); rd(5'd14, v); chk("R9 final pointer", 32'(v), 32'd4);
      exp_lat[3] = 16'd4;
      // R10: wrap under both stepping functions
      wr(5'd13, 16'h0000); wr(5'd14, 16'hFFFF);
      wr(5'd13, 16'h8000); rd(5'd14, v);
      chk("R10 access at top", 32'(l_addr), 32'hFFFF);
      rd(5'd14, v); chk("R10 next is zero", 32'(l_addr), 32'h0);
      wr(5'd13, 16'h0000); wr(5'd14, 16'hFFFF);
      wr(5'd13, 16'hC000); wr(5'd14, 16'h1234);
      wr(5'd13, 16'h0000); rd(5'd14, v); chk("R10 write wrap", 32'(v), 32'h0);
      exp_lat[0] = 16'h0;
      // R4: untouched devices intact after all of the above
      for (int d = 0; d < 32; d++) begin
         wr(5'd13, 16'(d)); rd(5'd14, v); chk("R4 latch kept", 32'(v), 32'(exp_lat[d]));
      end
      // R11: passthrough on every other register number
      wr(5'd13, 16'h8002);
      n0 = ext_cnt;
      for (int a = 0; a < 32; a++) begin
         if (a != 13 && a != 14) begin
            wr(5'(a), 16'(16'hA500 + a));
            chk("R11 base write", {lb_addr, lb_wdata}, {5'(a), 16'(16'hA500 + a)});
            rd(5'(a), v); chk("R11 base read", 32'(v), {16'h0, 8'hB0, 3'b000, 5'(a)});
         end
      end
      chk("R11 no ext strobe", 32'(ext_cnt - n0), 32'd0);
      rd(5'd13, v); chk("R11 ctrl kept", 32'(v), 32'h8002);
      wr(5'd13, 16'h0002); rd(5'd14, v); chk("R11 latch kept", 32'(v), 32'(exp_lat[2]));
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule